// File: doc/BRIEF.md
# Dual-Width CSR Access Unit

This block is one slice of a control/status register file. It holds a small set of registers that are always 64 bits wide. Software reaches them through a CSR port whose access width follows the currently active XLEN. Each register has two addresses: a base address and a high-half alias.

When the active XLEN is 64, the base address covers the whole register, and any touch of the alias is refused. When the active XLEN is 32, the base address covers bits 31:0 and the alias covers bits 63:32. The half that is not addressed is left alone. The stored 64-bit value never depends on the width being used, so software may switch widths at any time without losing data. The split access behaves the same way as the paired low/high access to 64-bit counters from 32-bit code.

Only the active XLEN decides legality and width. The XLEN configured for the mode that owns a register plays no part. Privilege rules other than this width rule, trap generation and the rest of the CSR file belong to other blocks.

Top module: `dwcsr_unit`

## Requirements
- R1: Every register keeps all 64 bits while the active XLEN is 32. At XLEN 32, writing the low half through the base address and the high half through the alias gives a full 64-bit value, which a later XLEN 64 base read returns.
- R2: With `xlen64_i`=1, a base-address access returns all 64 bits on `rdata_o`, and a modifying operation acts on all 64 bits using `wdata_i[63:0]`.
- R3: With `xlen64_i`=0, a base-address access returns bits 31:0 of the register on `rdata_o[31:0]` with `rdata_o[63:32]`=0. A modifying operation changes only bits 31:0, using `wdata_i[31:0]`, and leaves bits 63:32 unchanged.
- R4: With `xlen64_i`=0, an alias access returns bits 63:32 on `rdata_o[31:0]` with `rdata_o[63:32]`=0. A modifying operation changes only bits 63:32, using `wdata_i[31:0]`, and leaves bits 31:0 unchanged.
- R5: With `xlen64_i`=1, any request to an alias address sets `illegal_o`=1 and drives `rdata_o`=0, whatever the operation. The register is not changed. `illegal_o` is 0 in every other case.
- R6: The operation codes on `op_i` are:
  - 2'b00: read only.
  - 2'b01: write, so the new value equals the data.
  - 2'b10: set bits, so the new value is the old value OR the data.
  - 2'b11: clear bits, so the new value is the old value AND NOT the data.
- R7: Bits that are 0 in a register's writable mask always read as 0 and ignore every operation. With the default settings:
  - Register 0 has the mask 64'hC000_0000_0000_00F1.
  - Register 1 has the mask all ones.
- R8: Switching the active XLEN from 64 to 32 and back to 64 does not alter the upper 32 bits of any register.
- R9: `rdata_o` and `illegal_o` depend combinationally on the current inputs. A modification takes effect at the next rising clock edge. A synchronous `rst`=1 clears every register to 0.
- R10: Register i sits at base address `BASE_ADDR`+i (default 12'h640) and alias address `HIGH_ADDR`+i (default 12'h650). A request to any other address, or with `req_i`=0, returns `rdata_o`=0 and `illegal_o`=0, and changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| xlen64_i | input | 1 | Active XLEN: 1 = 64, 0 = 32 |
| req_i | input | 1 | Access request valid |
| addr_i | input | 12 | CSR address |
| op_i | input | 2 | Operation: 00 read, 01 write, 10 set, 11 clear |
| wdata_i | input | 64 | Write data, of which only bits 31:0 are used at XLEN 32 |
| rdata_o | output | 64 | Combinational read data |
| illegal_o | output | 1 | Alias access at XLEN 64 |

## Verification
The assertions assume three things about the inputs:
- `xlen64_i`, `addr_i`, `op_i` and `wdata_i` are steady around the rising edge.
- `req_i` qualifies every access.
- Reset is held for at least one edge before the first request.

The bench changes inputs only on falling edges, raises a request for one cycle at a time, and holds reset over two edges at start. The sweep covers both registers, both widths, both addresses, all four operations and several data patterns. It also covers an address outside the slice and a reset in the middle of the run, all within those assumptions.

// File: rtl/dwcsr_pkg.sv
package dwcsr_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SET   = 2'b10,
    OP_CLEAR = 2'b11
  } csr_op_e;

  localparam int WORD_W = 64;
  localparam int LANE_W = 32;

  // Applies one operation to a 32-bit lane.
  function automatic logic [LANE_W-1:0] lane_apply(
      input csr_op_e op, input logic [LANE_W-1:0] old, input logic [LANE_W-1:0] src);
    case (op)
      OP_WRITE: lane_apply = src;
      OP_SET:   lane_apply = old | src;
      OP_CLEAR: lane_apply = old & ~src;
      default:  lane_apply = old;
    endcase
  endfunction

  function automatic logic op_modifies(input csr_op_e op);
    op_modifies = (op != OP_READ);
  endfunction
endpackage

// File: rtl/dwcsr_decode.sv
module dwcsr_decode
  import dwcsr_pkg::*;
#(
  parameter int NUM_REGS = 2,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h640,
  parameter logic [ADDR_W-1:0] HIGH_ADDR = 12'h650
) (
  input  logic                req,
  input  logic                xlen64,
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_REGS-1:0] sel_lo,
  output logic [NUM_REGS-1:0] sel_hi,
  output logic                illegal
);
  logic [NUM_REGS-1:0] hi_match;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] ALO = BASE_ADDR + ADDR_W'(i);
    localparam logic [ADDR_W-1:0] AHI = HIGH_ADDR + ADDR_W'(i);
    assign sel_lo[i]   = req && (addr == ALO);
    assign hi_match[i] = req && (addr == AHI);
    assign sel_hi[i]   = hi_match[i] && !xlen64;
  end

  assign illegal = xlen64 && (|hi_match);
endmodule

// File: rtl/dwcsr_reg.sv
module dwcsr_reg
  import dwcsr_pkg::*;
#(
  parameter logic [WORD_W-1:0] WR_MASK = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xlen64,
  input  logic              sel_lo,
  input  logic              sel_hi,
  input  csr_op_e           op,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] q,
  output logic [WORD_W-1:0] rd
);
  logic              wr_lo, wr_hi;
  logic [LANE_W-1:0] hi_src, next_lo, next_hi;
  logic [WORD_W-1:0] d;

  assign wr_lo   = sel_lo && op_modifies(op);
  assign wr_hi   = op_modifies(op) && (sel_hi || (sel_lo && xlen64));
  assign hi_src  = xlen64 ? wdata[WORD_W-1:LANE_W] : wdata[LANE_W-1:0];
  assign next_lo = lane_apply(op, q[LANE_W-1:0], wdata[LANE_W-1:0]);
  assign next_hi = lane_apply(op, q[WORD_W-1:LANE_W], hi_src);

  always_comb begin
    d = q;
    if (wr_lo) d[LANE_W-1:0] = next_lo;
    if (wr_hi) d[WORD_W-1:LANE_W] = next_hi;
    d = d & WR_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

  always_comb begin
    rd = '0;
    if (sel_lo && xlen64)       rd = q;
    else if (sel_lo)            rd[LANE_W-1:0] = q[LANE_W-1:0];
    else if (sel_hi)            rd[LANE_W-1:0] = q[WORD_W-1:LANE_W];
  end

  p_low_write_keeps_high_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && !wr_hi) |=> $stable(q[WORD_W-1:LANE_W]));
  p_high_write_keeps_low_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_hi && !wr_lo) |=> $stable(q[LANE_W-1:0]));
  p_idle_holds_r10: assert property (@(posedge clk) disable iff (rst)
    (!wr_lo && !wr_hi) |=> $stable(q));
  p_masked_zero_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((q & ~WR_MASK) == '0));
  p_narrow_read_r3: assert property (@(posedge clk) disable iff (rst)
    (!xlen64) |-> (rd[WORD_W-1:LANE_W] == '0));
endmodule

// File: rtl/dwcsr_unit.sv
module dwcsr_unit
  import dwcsr_pkg::*;
#(
  parameter int NUM_REGS = 2,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h640,
  parameter logic [ADDR_W-1:0] HIGH_ADDR = 12'h650,
  parameter logic [NUM_REGS-1:0][63:0] WR_MASK =
    {64'hFFFF_FFFF_FFFF_FFFF, 64'hC000_0000_0000_00F1}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xlen64_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        op_i,
  input  logic [63:0]       wdata_i,
  output logic [63:0]       rdata_o,
  output logic              illegal_o
);
  localparam int FLAT_W = NUM_REGS * WORD_W;

  logic [NUM_REGS-1:0]             sel_lo, sel_hi;
  logic [NUM_REGS-1:0][WORD_W-1:0] q_all, rd_all;
  logic [FLAT_W-1:0]               q_flat;
  csr_op_e                         op;

  assign op = csr_op_e'(op_i);

  dwcsr_decode #(
    .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W),
    .BASE_ADDR(BASE_ADDR), .HIGH_ADDR(HIGH_ADDR)
  ) u_dec (
    .req(req_i), .xlen64(xlen64_i), .addr(addr_i),
    .sel_lo(sel_lo), .sel_hi(sel_hi), .illegal(illegal_o)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    dwcsr_reg #(.WR_MASK(WR_MASK[i])) u_reg (
      .clk(clk), .rst(rst), .xlen64(xlen64_i),
      .sel_lo(sel_lo[i]), .sel_hi(sel_hi[i]), .op(op), .wdata(wdata_i),
      .q(q_all[i]), .rd(rd_all[i])
    );
  end

  assign q_flat = q_all;

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++) rdata_o = rdata_o | rd_all[i];
  end

  p_illegal_no_change_r5: assert property (@(posedge clk) disable iff (rst)
    illegal_o |=> $stable(q_flat));
  p_illegal_zero_read_r5: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (rdata_o == '0));
  p_single_target_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel_lo, sel_hi}));
  p_no_req_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !req_i |-> (!illegal_o && rdata_o == '0));
  p_narrow_never_illegal_r4: assert property (@(posedge clk) disable iff (rst)
    !xlen64_i |-> !illegal_o);
endmodule

// File: tb/dwcsr_unit_test.sv
module dwcsr_unit_test;
  localparam logic [11:0] BASE = 12'h640;
  localparam logic [11:0] HIGH = 12'h650;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        xlen64_i = 1'b1;
  logic        req_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [1:0]  op_i = '0;
  logic [63:0] wdata_i = '0;
  logic [63:0] rdata_o;
  logic        illegal_o;

  int checks = 0;
  int fails = 0;
  logic [63:0] mdl [2];

  dwcsr_unit uut (
    .clk(clk), .rst(rst), .xlen64_i(xlen64_i), .req_i(req_i), .addr_i(addr_i),
    .op_i(op_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .illegal_o(illegal_o)
  );

  always #4 clk = ~clk;

  function automatic logic [63:0] keep_bits(input int r);
    return (r == 0) ? 64'hC000_0000_0000_00F1 : 64'hFFFF_FFFF_FFFF_FFFF;
  endfunction

  function automatic logic [31:0] half_op(input logic [1:0] o, input logic [31:0] v,
                                          input logic [31:0] s);
    if (o == 2'b01) return s;
    if (o == 2'b10) return v | s;
    if (o == 2'b11) return v & ~s;
    return v;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One request for one cycle; called right after a falling edge.
  task automatic acc(input logic x, input logic [11:0] a, input logic [1:0] o,
                     input logic [63:0] d, input string tag);
    int r;
    logic hi, hit, ill;
    logic [63:0] erd, nv;
    hit = 1'b0; hi = 1'b0; r = 0;
    if (a == BASE || a == BASE + 12'd1) begin hit = 1'b1; r = int'(a - BASE); end
    if (a == HIGH || a == HIGH + 12'd1) begin hit = 1'b1; hi = 1'b1; r = int'(a - HIGH); end
    ill = hit && hi && x;
    erd = 64'd0;
    nv = hit ? mdl[r] : 64'd0;
    if (hit && !ill) begin
      if (x) begin
        erd = mdl[r];
        nv = {half_op(o, mdl[r][63:32], d[63:32]), half_op(o, mdl[r][31:0], d[31:0])};
      end else if (hi) begin
        erd = {32'd0, mdl[r][63:32]};
        nv[63:32] = half_op(o, mdl[r][63:32], d[31:0]);
      end else begin
        erd = {32'd0, mdl[r][31:0]};
        nv[31:0] = half_op(o, mdl[r][31:0], d[31:0]);
      end
    end
    xlen64_i = x; addr_i = a; op_i = o; wdata_i = d; req_i = 1'b1;
    #1;
    chk({tag, " rdata"}, rdata_o, erd);
    chk({tag, " illegal"}, {63'd0, illegal_o}, {63'd0, ill});
    @(posedge clk);
    if (hit) mdl[r] = nv & keep_bits(r);
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic verify_all(input string tag);
    for (int r = 0; r < 2; r++) acc(1'b1, BASE + 12'(r), 2'b00, 64'd0, tag);
  endtask

  logic [63:0] pats [4];

  initial begin
    pats[0] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[1] = 64'h0000_0000_0000_0000;
    pats[2] = 64'hA5A5_5A5A_0F0F_F0F0;
    pats[3] = 64'h1234_5678_9ABC_DEF1;
    mdl[0] = '0; mdl[1] = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    verify_all("R9 reset state");

    // Sweep: register, width, address kind, operation, data pattern (R2 R3 R4 R5 R6 R7)
    for (int r = 0; r < 2; r++)
      for (int x = 0; x < 2; x++)
        for (int h = 0; h < 2; h++)
          for (int o = 0; o < 4; o++)
            for (int p = 0; p < 4; p++) begin
              acc(x[0], (h != 0 ? HIGH : BASE) + 12'(r), o[1:0], pats[p],
                  $sformatf("R2/R3/R4/R5/R6/R7 sweep r%0d x%0d h%0d op%0d", r, x, h, o));
              verify_all("R1 full readback");
            end

    // R1: assemble 64 bits from two narrow writes
    acc(1'b0, BASE + 12'd1, 2'b01, 64'h0000_0000_CAFE_F00D, "R1 low write");
    acc(1'b0, HIGH + 12'd1, 2'b01, 64'h0000_0000_1357_9BDF, "R1 high write");
    acc(1'b1, BASE + 12'd1, 2'b00, 64'd0, "R1 wide read");
    chk("R1 assembled", mdl[1], 64'h1357_9BDF_CAFE_F00D);

    // R8: width switch keeps upper half
    acc(1'b1, BASE + 12'd1, 2'b01, 64'hDEAD_BEEF_0000_1111, "R8 wide write");
    acc(1'b0, BASE + 12'd1, 2'b01, 64'h0000_0000_2222_3333, "R8 narrow low");
    acc(1'b0, HIGH + 12'd1, 2'b00, 64'd0, "R8 narrow high read");
    acc(1'b1, BASE + 12'd1, 2'b00, 64'd0, "R8 back to wide");
    chk("R8 upper kept", mdl[1], 64'hDEAD_BEEF_2222_3333);

    // R5: alias at wide width with a clear-all, register must stay
    acc(1'b1, HIGH + 12'd1, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF, "R5 alias clear");
    verify_all("R5 unchanged");

    // R10: out-of-slice address and no request
    acc(1'b1, BASE + 12'd2, 2'b01, 64'h0, "R10 foreign addr");
    acc(1'b0, HIGH + 12'd7, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF, "R10 foreign alias");
    xlen64_i = 1'b1; addr_i = BASE + 12'd1; op_i = 2'b01; wdata_i = '0; req_i = 1'b0;
    #1;
    chk("R10 idle rdata", rdata_o, 64'd0);
    @(negedge clk);
    verify_all("R10 unchanged");

    // R9: reset in the middle of the run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    mdl[0] = '0; mdl[1] = '0;
    verify_all("R9 mid-run reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule